// File: doc/BRIEF.md
# Serial Audio Transmitter with Master/Slave Clocking

This block sends stereo PCM samples out over a three-wire serial audio link: a bit clock, a word clock and a data line. Framing is I2S, left-justified or right-justified. The word length is 16, 18, 20 or 24 bits. Framing and word length are set by two independent configuration inputs. A left/right sample pair enters through a ready/valid handshake. The block takes a new pair only at the start of a frame. If no pair is offered at that moment, it sends the previous pair again.

In master mode the block divides its system clock to make the bit clock and the word clock. It produces 64 bit clocks per frame, and the word clock has a 50% duty cycle. In slave mode the block passes both external clocks through synchronizers into the system clock domain and follows them. It measures how many bit clocks each half-frame lasts, which lets right-justified data end exactly at the next word-clock edge whatever the slot length. In both modes the data line changes on the falling bit-clock edge, so the receiver samples it on the rising edge. The word clock is low for the left channel.

The framer is a three-state machine:
- `ST_IDLE` is the state after reset; the data line is held low.
- `ST_LEFT` covers the word-clock-low half.
- `ST_RIGHT` covers the word-clock-high half.

The transitions are:
- IDLE→LEFT on the first falling word-clock edge.
- LEFT→RIGHT on a rising word-clock edge.
- RIGHT→LEFT on a falling word-clock edge. This is the frame start, where a pair is accepted and the configuration is captured.

Top module: `pcm_serial_tx`

## Requirements
- R1: While reset is asserted, `sdata`, `s_ready` and `sclk_out` are low, and the block sends nothing until the first falling word-clock edge.
- R2: In master mode (`master_en`=1), `sclk_out` has a period of 2·DIV_HALF system clocks. Each frame has 64 bit clocks, and `wclk_out` is low for the first 32 of them and high for the last 32.
- R3: In slave mode (`master_en`=0), `sclk_out` and `wclk_out` are held low, and frame timing follows `sclk_in`/`wclk_in` with any half-frame length up to MAX_SLOT bit clocks.
- R4: The `wlen` input selects the word length: 0=16, 1=18, 2=20, 3=24 bits. The sample occupies the low W bits of `s_left`/`s_right`, and the upper bits are ignored.
- R5: When `fmt` is 0 or 3 (left-justified), the MSB goes out in bit position 0 of a half-frame, where position 0 is the bit clock whose falling edge coincides with the word-clock change, and the bits follow MSB first.
- R6: When `fmt` is 1 (I2S), the MSB goes out in bit position 1, one bit clock after the word-clock change.
- R7: When `fmt` is 2 (right-justified), the LSB goes out in position L−1. L is the length of the most recently completed half-frame (32 after reset, and always 32 in master mode).
- R8: Every bit position that the sample does not occupy is driven low.
- R9: `sdata` changes only on a falling bit-clock edge and stays stable while the bit clock is high.
- R10: `s_ready` is a single-cycle pulse issued only at a frame start. A pair is accepted when `s_valid` and `s_ready` are high together.
- R11: When no pair is accepted at a frame start, the previous pair is sent again unchanged.
- R12: `fmt` and `wlen` are captured at each frame start, so a change in the middle of a frame takes effect at the next frame.
- R13: The left sample is sent while the word clock is low and the right sample while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_en | input | 1 | 1 = generate clocks, 0 = follow external clocks |
| fmt | input | 2 | Framing: 0 left-justified, 1 I2S, 2 right-justified, 3 left-justified |
| wlen | input | 2 | Word length code: 16/18/20/24 bits |
| sclk_in | input | 1 | External bit clock (slave mode) |
| wclk_in | input | 1 | External word clock (slave mode) |
| s_valid | input | 1 | Sample pair offered |
| s_left | input | 24 | Left sample, right-aligned |
| s_right | input | 24 | Right sample, right-aligned |
| s_ready | output | 1 | Pair accepted at this frame start |
| sclk_out | output | 1 | Generated bit clock (master mode) |
| wclk_out | output | 1 | Generated word clock (master mode) |
| sdata | output | 1 | Serial data |

## Verification
The bench targets the following corner cases:

- **Right-justified data in a 24-bit slave slot.** A design that assumed a fixed 32-bit slot would start the word eight positions late and cut off its low bits.
- **The I2S one-bit delay.** An off-by-one error would shift every bit and leak the MSB into position 0.
- **Upper bits above the word length.** A design that used them would send the wrong bits.
- **A configuration change in the middle of a frame.** A design that read the configuration live would change format halfway through the frame.
- **Frames where no pair is offered.** A design that sent zeros instead of repeating the previous pair would fail these frames.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;

    localparam int SAMPLE_W = 24;

    typedef enum logic [1:0] {
        FMT_LJ     = 2'd0,
        FMT_I2S    = 2'd1,
        FMT_RJ     = 2'd2,
        FMT_LJ_ALT = 2'd3
    } fmt_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEFT  = 2'd1,
        ST_RIGHT = 2'd2
    } tx_state_e;

    function automatic int word_bits(input logic [1:0] code);
        unique case (code)
            2'd0:    return 16;
            2'd1:    return 18;
            2'd2:    return 20;
            default: return 24;
        endcase
    endfunction

endpackage

// File: rtl/pcm_tx_clkgen.sv
module pcm_tx_clkgen #(
    parameter int DIV_HALF   = 2,
    parameter int FRAME_BITS = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    output logic sclk,
    output logic wclk,
    output logic tick,
    output logic lr_next
);
    localparam int DIV_W = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
    localparam int CNT_W = $clog2(FRAME_BITS);
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV_HALF - 1);

    logic [DIV_W-1:0] div_q;
    logic [CNT_W-1:0] bit_q;
    logic [CNT_W-1:0] bit_nxt;
    logic             sclk_q;
    logic             wclk_q;
    logic             half_end;

    always_comb begin
        half_end = (div_q == DIV_LAST);
        tick     = enable && half_end && sclk_q;
        bit_nxt  = bit_q + 1'b1;
        lr_next  = bit_nxt[CNT_W-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q  <= '0;
            sclk_q <= 1'b0;
            bit_q  <= '1;
            wclk_q <= 1'b1;
        end else if (!enable) begin
            div_q  <= '0;
            sclk_q <= 1'b0;
            bit_q  <= '1;
            wclk_q <= 1'b1;
        end else if (half_end) begin
            div_q  <= '0;
            sclk_q <= ~sclk_q;
            if (sclk_q) begin
                bit_q  <= bit_nxt;
                wclk_q <= lr_next;
            end
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    assign sclk = sclk_q;
    assign wclk = wclk_q;

    // R2
    wclk_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n || !enable)
        !$stable(wclk_q) |-> $fell(sclk_q));

endmodule

// File: rtl/pcm_tx_slave_sync.sv
module pcm_tx_slave_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_in,
    input  logic wclk_in,
    output logic tick,
    output logic lr
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sclk_sr;
    logic [SYNC_STAGES-1:0] wclk_sr;
    logic                   sclk_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_sr <= '1;
            wclk_sr <= '1;
            sclk_d  <= 1'b1;
        end else begin
            sclk_sr <= {sclk_sr[SYNC_STAGES-2:0], sclk_in};
            wclk_sr <= {wclk_sr[SYNC_STAGES-2:0], wclk_in};
            sclk_d  <= sclk_sr[TOP];
        end
    end

    assign tick = sclk_d && !sclk_sr[TOP];
    assign lr   = wclk_sr[TOP];

endmodule

// File: rtl/pcm_tx_framer.sv
module pcm_tx_framer
    import pcm_tx_pkg::*;
#(
    parameter int SMP_W    = SAMPLE_W,
    parameter int MAX_SLOT = 64,
    parameter int DEF_SLOT = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             lr,
    input  logic [1:0]       fmt_in,
    input  logic [1:0]       wlen_in,
    input  logic             s_valid,
    input  logic [SMP_W-1:0] s_left,
    input  logic [SMP_W-1:0] s_right,
    output logic             s_ready,
    output logic             sdata
);
    localparam int POS_W = $clog2(MAX_SLOT) + 1;
    localparam int IDX_W = $clog2(SMP_W);
    localparam logic [POS_W-1:0] POS_MAX = '1;

    tx_state_e        state_q, state_d;
    logic             lr_prev_q;
    logic [POS_W-1:0] pos_q, pos_nxt;
    logic [POS_W-1:0] slot_q;
    fmt_e             fmt_q, fmt_use;
    logic [1:0]       wlen_q, wlen_use;
    logic [SMP_W-1:0] hold_l, hold_r, word;
    logic             sdata_q;
    logic             wc_edge, frame_start, accept, bit_sel;
    logic [IDX_W-1:0] kidx;
    int               p_i, len_i, w_i, k_i;
    logic             in_word;

    always_comb begin
        wc_edge     = tick && (lr != lr_prev_q);
        frame_start = wc_edge && !lr;
        accept      = frame_start && s_valid;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (tick) begin
            unique case (state_q)
                ST_IDLE:  if (frame_start)      state_d = ST_LEFT;
                ST_LEFT:  if (wc_edge && lr)    state_d = ST_RIGHT;
                ST_RIGHT: if (frame_start)      state_d = ST_LEFT;
                default:                        state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output bit selection
    always_comb begin
        fmt_use  = frame_start ? fmt_e'(fmt_in) : fmt_q;
        wlen_use = frame_start ? wlen_in : wlen_q;
        if (wc_edge)              pos_nxt = '0;
        else if (pos_q == POS_MAX) pos_nxt = pos_q;
        else                      pos_nxt = pos_q + 1'b1;
        len_i   = (wc_edge && state_q != ST_IDLE) ? int'(pos_q) + 1 : int'(slot_q);
        word    = lr ? hold_r : (accept ? s_left : hold_l);
        p_i     = int'(pos_nxt);
        w_i     = word_bits(wlen_use);
        in_word = 1'b0;
        k_i     = 0;
        unique case (fmt_use)
            FMT_I2S: if (p_i >= 1 && p_i <= w_i) begin
                in_word = 1'b1;
                k_i     = w_i - p_i;
            end
            FMT_RJ: if (p_i >= len_i - w_i && p_i < len_i) begin
                in_word = 1'b1;
                k_i     = len_i - 1 - p_i;
            end
            default: if (p_i < w_i) begin
                in_word = 1'b1;
                k_i     = w_i - 1 - p_i;
            end
        endcase
        kidx    = k_i[IDX_W-1:0];
        bit_sel = in_word && word[kidx];
    end

    // Output and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lr_prev_q <= 1'b1;
            pos_q     <= '0;
            slot_q    <= POS_W'(DEF_SLOT);
            fmt_q     <= FMT_LJ;
            wlen_q    <= 2'd3;
            hold_l    <= '0;
            hold_r    <= '0;
            sdata_q   <= 1'b0;
        end else begin
            if (tick) begin
                lr_prev_q <= lr;
                pos_q     <= pos_nxt;
                sdata_q   <= (state_d != ST_IDLE) && bit_sel;
                if (wc_edge && state_q != ST_IDLE)
                    slot_q <= (pos_q == POS_MAX) ? POS_MAX : pos_q + 1'b1;
                if (frame_start) begin
                    fmt_q  <= fmt_use;
                    wlen_q <= wlen_use;
                end
            end
            if (accept) begin
                hold_l <= s_left;
                hold_r <= s_right;
            end
        end
    end

    assign s_ready = frame_start;
    assign sdata   = sdata_q;

    // R10
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |=> !s_ready);

    // R11
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> ($stable(hold_l) && $stable(hold_r)));

    // R12
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> ($stable(fmt_q) && $stable(wlen_q)));

    // R13
    chan_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RIGHT) |-> lr_prev_q);

endmodule

// File: rtl/pcm_serial_tx.sv
module pcm_serial_tx
    import pcm_tx_pkg::*;
#(
    parameter int DIV_HALF    = 2,
    parameter int SYNC_STAGES = 2,
    parameter int MAX_SLOT    = 64,
    parameter int SMP_W       = SAMPLE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             master_en,
    input  logic [1:0]       fmt,
    input  logic [1:0]       wlen,
    input  logic             sclk_in,
    input  logic             wclk_in,
    input  logic             s_valid,
    input  logic [SMP_W-1:0] s_left,
    input  logic [SMP_W-1:0] s_right,
    output logic             s_ready,
    output logic             sclk_out,
    output logic             wclk_out,
    output logic             sdata
);
    localparam int FRAME_BITS = 64;

    logic m_sclk, m_wclk, m_tick, m_lr;
    logic s_tick, s_lr;
    logic tick, lr;

    pcm_tx_clkgen #(
        .DIV_HALF   (DIV_HALF),
        .FRAME_BITS (FRAME_BITS)
    ) u_clkgen (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (master_en),
        .sclk    (m_sclk),
        .wclk    (m_wclk),
        .tick    (m_tick),
        .lr_next (m_lr)
    );

    pcm_tx_slave_sync #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_in (sclk_in),
        .wclk_in (wclk_in),
        .tick    (s_tick),
        .lr      (s_lr)
    );

    assign tick     = master_en ? m_tick : s_tick;
    assign lr       = master_en ? m_lr   : s_lr;
    assign sclk_out = master_en && m_sclk;
    assign wclk_out = master_en && m_wclk;

    pcm_tx_framer #(
        .SMP_W    (SMP_W),
        .MAX_SLOT (MAX_SLOT),
        .DEF_SLOT (FRAME_BITS / 2)
    ) u_framer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .lr      (lr),
        .fmt_in  (fmt),
        .wlen_in (wlen),
        .s_valid (s_valid),
        .s_left  (s_left),
        .s_right (s_right),
        .s_ready (s_ready),
        .sdata   (sdata)
    );

    // R9
    data_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (master_en && sclk_out && $past(sclk_out)) |-> $stable(sdata));

endmodule

// File: tb/test_pcm_serial_tx.sv
module test_pcm_serial_tx;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        master_en = 1'b1;
    logic [1:0]  fmt = 2'd0;
    logic [1:0]  wlen = 2'd3;
    logic        sclk_in = 1'b1;
    logic        wclk_in = 1'b1;
    logic        s_valid = 1'b0;
    logic [23:0] s_left = '0;
    logic [23:0] s_right = '0;
    logic        s_ready, sclk_out, wclk_out, sdata;

    int          n_checks = 0;
    int          n_fail = 0;
    bit          done = 1'b0;
    logic [23:0] acc_l = '0;
    logic [23:0] acc_r = '0;

    pcm_serial_tx i_pcm_serial_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .master_en (master_en),
        .fmt       (fmt),
        .wlen      (wlen),
        .sclk_in   (sclk_in),
        .wclk_in   (wclk_in),
        .s_valid   (s_valid),
        .s_left    (s_left),
        .s_right   (s_right),
        .s_ready   (s_ready),
        .sclk_out  (sclk_out),
        .wclk_out  (wclk_out),
        .sdata     (sdata)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Records accepted pairs and withdraws the offer after acceptance
    initial begin
        forever begin
            @(negedge clk);
            if (s_valid && s_ready) begin
                acc_l = s_left;
                acc_r = s_right;
                @(posedge clk);
                #1;
                s_valid = 1'b0;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_half(input logic [1:0] f, input logic [1:0] wl,
                                             input int slot, input logic [23:0] smp);
        logic [63:0] v = '0;
        int w = (wl == 2'd0) ? 16 : (wl == 2'd1) ? 18 : (wl == 2'd2) ? 20 : 24;
        for (int p = 0; p < slot; p++) begin
            if (f == 2'd1) begin
                if (p >= 1 && p <= w) v[p] = smp[w - p];
            end else if (f == 2'd2) begin
                if (p >= slot - w) v[p] = smp[slot - 1 - p];
            end else begin
                if (p < w) v[p] = smp[w - 1 - p];
            end
        end
        return v;
    endfunction

    task automatic reset_dut(input logic mode);
        rst_n = 1'b0;
        master_en = mode;
        sclk_in = 1'b1;
        wclk_in = 1'b1;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(sdata == 1'b0 && s_ready == 1'b0 && sclk_out == 1'b0, "R1", "outputs in reset",
            {61'd0, sdata, s_ready, sclk_out}, 64'd0);
        if (!mode)
            // R3: slave mode clock outputs low
            chk(!sclk_out && !wclk_out, "R3", "clock outputs in slave mode",
                {62'd0, sclk_out, wclk_out}, 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic m_align();
        if (!wclk_out) @(posedge wclk_out);
        @(negedge wclk_out);
    endtask

    task automatic m_capture(input int chg_at, input logic [1:0] cf, input logic [1:0] cw,
                             output logic [63:0] d, output logic [63:0] w, output bit held_ok);
        held_ok = 1'b1;
        for (int p = 0; p < 64; p++) begin
            @(posedge sclk_out);
            #1;
            d[p] = sdata;
            w[p] = wclk_out;
            @(negedge clk);
            if (sdata !== d[p] || !sclk_out) held_ok = 1'b0;
            if (p == chg_at) begin
                fmt = cf;
                wlen = cw;
            end
        end
    endtask

    task automatic master_case(input logic [1:0] f, input logic [1:0] wl,
                               input logic [23:0] l, input logic [23:0] r, input string req);
        logic [63:0] d, w, el, er;
        bit held;
        fmt = f;
        wlen = wl;
        s_left = l;
        s_right = r;
        s_valid = 1'b1;
        m_align();
        m_capture(-1, 2'd0, 2'd0, d, w, held);
        el = exp_half(f, wl, 32, l);
        er = exp_half(f, wl, 32, r);
        chk(w == {32'hFFFF_FFFF, 32'h0}, "R2", "word clock pattern", w, {32'hFFFF_FFFF, 32'h0});
        chk(acc_l == l && acc_r == r, "R10", "pair accepted", {16'd0, acc_l, acc_r}, {16'd0, l, r});
        chk(d[31:0] == el[31:0], req, "left half (R13, R8, R4)", {32'd0, d[31:0]}, {32'd0, el[31:0]});
        chk(d[63:32] == er[31:0], req, "right half (R13, R8, R4)", {32'd0, d[63:32]}, {32'd0, er[31:0]});
        chk(held, "R9", "data stable while bit clock high", {63'd0, held}, 64'd1);
    endtask

    task automatic master_repeat();
        logic [63:0] d, w, el, er;
        bit held;
        master_case(2'd2, 2'd1, 24'h02A5C7, 24'h03F00F, "R7");
        m_capture(-1, 2'd0, 2'd0, d, w, held);
        el = exp_half(2'd2, 2'd1, 32, 24'h02A5C7);
        er = exp_half(2'd2, 2'd1, 32, 24'h03F00F);
        // R11: no pair offered, previous pair repeated
        chk({d[63:32], d[31:0]} == {er[31:0], el[31:0]}, "R11", "repeated frame", d, {er[31:0], el[31:0]});
    endtask

    task automatic master_cfg_mid();
        logic [63:0] d, w, el, er;
        bit held;
        fmt = 2'd0;
        wlen = 2'd0;
        s_left = 24'h00B00D;
        s_right = 24'h007E57;
        s_valid = 1'b1;
        m_align();
        m_capture(8, 2'd2, 2'd3, d, w, held);
        el = exp_half(2'd0, 2'd0, 32, 24'h00B00D);
        er = exp_half(2'd0, 2'd0, 32, 24'h007E57);
        // R12: change mid-frame ignored in current frame
        chk(d == {er[31:0], el[31:0]}, "R12", "frame after mid change", d, {er[31:0], el[31:0]});
        m_capture(-1, 2'd0, 2'd0, d, w, held);
        el = exp_half(2'd2, 2'd3, 32, 24'h00B00D);
        er = exp_half(2'd2, 2'd3, 32, 24'h007E57);
        chk(d == {er[31:0], el[31:0]}, "R12", "next frame uses new config", d, {er[31:0], el[31:0]});
    endtask

    task automatic slave_bit(input logic wc, output logic b);
        sclk_in = 1'b0;
        wclk_in = wc;
        repeat (8) @(negedge clk);
        sclk_in = 1'b1;
        b = sdata;
        repeat (8) @(negedge clk);
    endtask

    task automatic slave_frame(input int slot, output logic [63:0] dl, output logic [63:0] dr);
        logic b;
        dl = '0;
        dr = '0;
        for (int p = 0; p < 2 * slot; p++) begin
            slave_bit(p >= slot, b);
            if (p < slot) dl[p] = b;
            else dr[p - slot] = b;
        end
    endtask

    task automatic slave_case(input logic [1:0] f, input logic [1:0] wl, input int slot,
                              input logic [23:0] l, input logic [23:0] r, input string req);
        logic [63:0] dl, dr, el, er;
        fmt = f;
        wlen = wl;
        s_left = l;
        s_right = r;
        s_valid = 1'b1;
        slave_frame(slot, dl, dr);
        chk(acc_l == l && acc_r == r, "R10", "slave pair accepted", {16'd0, acc_l, acc_r}, {16'd0, l, r});
        slave_frame(slot, dl, dr);
        el = exp_half(f, wl, slot, l);
        er = exp_half(f, wl, slot, r);
        chk(dl == el, req, "slave left half (R3, R11)", dl, el);
        chk(dr == er, req, "slave right half (R3, R11)", dr, er);
        chk(!sclk_out && !wclk_out, "R3", "clock outputs stay low", {62'd0, sclk_out, wclk_out}, 64'd0);
    endtask

    initial begin
        reset_dut(1'b1);
        master_case(2'd0, 2'd3, 24'hC3A55A, 24'h0F0F01, "R5");
        master_case(2'd1, 2'd0, 24'hFF8001, 24'h00FFFF, "R6");
        master_case(2'd2, 2'd2, 24'h9ABCDE, 24'h012345, "R7");
        master_case(2'd3, 2'd1, 24'h3FFFFF, 24'h2AAAAA, "R5");
        master_case(2'd0, 2'd0, 24'hAB0000, 24'hCD0000, "R8");
        master_repeat();
        master_cfg_mid();

        reset_dut(1'b0);
        @(negedge clk);
        slave_case(2'd2, 2'd0, 24, 24'hFF1234, 24'h00ABCD, "R7");
        slave_case(2'd1, 2'd3, 32, 24'h8000F1, 24'h7FFF0E, "R6");
        slave_case(2'd0, 2'd1, 24, 24'h03C3C3, 24'h012481, "R5");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule